// File: doc/BRIEF.md
# I2C bit-level transaction bridge

This block sits on the target side of a two-wire bus that a software-driven master toggles one wire at a time. It takes the already synchronised clock and data levels and compares each against the level it last saw. From those changes it recognises bus framing and assembles or serialises bytes. It then turns the result into single-cycle requests on a parallel downstream port. The requests cover opening a transfer (with target address and direction), writing a byte, fetching a byte, passing on a master NACK, and closing the transfer.

The downstream side answers in the same cycle. A refuse flag rejects an address or a data byte, and a data bus returns the byte to be read. The block drives its own data output, which is released high unless it acknowledges or returns a zero bit. It also presents the resolved wire level, which is that output ANDed with the master's data level, as a registered signal.

Top module: `i2c_bitbang_bridge`

## Requirements
- R1: After reset the device output and the resolved line output are both 1, and no downstream request is active while the wires stay high.
- R2: A falling data level while the clock is high (START) begins a new byte and invalidates the current address. A START in the middle of a transfer raises no end request, and the next byte is again treated as an address.
- R3: A rising data level while the clock is high (STOP) returns the block to idle. It raises one end request only if an address was accepted since the last START.
- R4: Data changes while the clock is low, and repeated unchanged levels on either wire, alter no state and raise no request.
- R5: Bits are sampled on clock rising edges, most significant bit first. On the rising edge of the ninth slot after START, a start request carries byte bits 7:1 as the address and bit 0 as the direction (1 = read).
- R6: In write direction, each later byte raises a write request with that byte at its ninth rising edge. When it is accepted, the device output is driven 0 for the acknowledge.
- R7: A refused address or data byte raises an end request in the same cycle and leaves the device output at 1 (NACK). The block then goes idle, so further clocks raise no request and a later STOP raises no end request.
- R8: In read direction, one read request is raised at the first rising edge of each byte. The returned byte appears on the device output most significant bit first, one bit per rising edge.
- R9: At the rising edge of the master acknowledge slot, data low starts the next read byte. Data high raises a nack request, after which clocks are ignored (device output 1, no requests) until START or STOP.
- R10: Every clock falling edge releases the device output to 1. The resolved line output equals device output AND master data level and is updated one clock after the causing input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronised bus clock level from the master |
| sda_i | input | 1 | Synchronised bus data level from the master |
| dev_sda_o | output | 1 | Device-side data drive (1 = released) |
| line_o | output | 1 | Registered resolved data line level |
| req_start_o | output | 1 | Open-transfer request pulse |
| req_addr_o | output | DATA_W-1 | Target address for the open request |
| req_rd_o | output | 1 | Direction for the open request (1 = read) |
| req_write_o | output | 1 | Write-byte request pulse |
| req_wdata_o | output | DATA_W | Byte for the write request |
| req_read_o | output | 1 | Read-byte request pulse |
| rsp_rdata_i | input | DATA_W | Byte returned for a read request, same cycle |
| rsp_refuse_i | input | 1 | Same-cycle refusal of an open or write request |
| req_nack_o | output | 1 | Master NACK notification pulse |
| req_end_o | output | 1 | End-of-transfer request pulse |

## Verification
The bench builds the block with its default byte width of 8, so the address is 7 bits and a byte spans eight rising edges plus one acknowledge slot. A responder accepts addresses 0x50 to 0x57, refuses the write byte 0xFF, and returns bytes from a counted sequence. This exercises both address outcomes, refusals in mid-write, multi-byte reads ending in a master NACK, and repeated STARTs from a write phase. Data toggles while the clock is low are mixed into address bytes to show they are not shifted in.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    typedef enum logic [2:0] {
        BR_IDLE,
        BR_WR,
        BR_ACK,
        BR_RD,
        BR_MACK,
        BR_HOLD
    } br_state_e;

endpackage

// File: rtl/i2cb_edge_track.sv
module i2cb_edge_track (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o,
    output logic bit_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } lvl_t;

    lvl_t lvl_d, lvl_q;
    logic scl_chg, sda_chg;

    always_comb begin
        lvl_d     = '{scl: scl_i, sda: sda_i};
        scl_chg   = (scl_i != lvl_q.scl);
        sda_chg   = (sda_i != lvl_q.sda);
        // a data change only frames the bus while the clock stays high
        start_o   = sda_chg && !scl_chg && lvl_q.scl && !sda_i;
        stop_o    = sda_chg && !scl_chg && lvl_q.scl &&  sda_i;
        rise_o    = scl_chg &&  scl_i;
        fall_o    = scl_chg && !scl_i;
        bit_o     = sda_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '{scl: 1'b1, sda: 1'b1};
        else        lvl_q <= lvl_d;
    end

    AST_FRAME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !((start_o || stop_o) && (rise_o || fall_o))); // R4

endmodule

// File: rtl/i2cb_core.sv
module i2cb_core
    import i2cb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              bit_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              refuse_i,
    output logic              dev_d_o,
    output logic              dev_q_o,
    output logic              req_start_o,
    output logic [DATA_W-2:0] req_addr_o,
    output logic              req_rd_o,
    output logic              req_write_o,
    output logic [DATA_W-1:0] req_wdata_o,
    output logic              req_read_o,
    output logic              req_nack_o,
    output logic              req_end_o
);

    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        br_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic              addr_ok;
        logic              rd_dir;
        logic              dev;
    } core_t;

    core_t n_d, n_q;
    logic [DATA_W-1:0] byte_v;
    logic              dir_v;
    logic              evt_any;

    always_comb begin
        n_d         = n_q;
        req_start_o = 1'b0;
        req_write_o = 1'b0;
        req_read_o  = 1'b0;
        req_nack_o  = 1'b0;
        req_end_o   = 1'b0;
        req_addr_o  = n_q.sh[DATA_W-1:1];
        req_rd_o    = n_q.sh[0];
        req_wdata_o = n_q.sh;
        byte_v      = n_q.sh;
        dir_v       = n_q.rd_dir;
        evt_any     = start_i || stop_i || rise_i || fall_i;

        if (start_i) begin
            n_d.st      = BR_WR;
            n_d.cnt     = '0;
            n_d.addr_ok = 1'b0;
            n_d.dev     = 1'b1;
        end else if (stop_i) begin
            req_end_o   = n_q.addr_ok;
            n_d.addr_ok = 1'b0;
            n_d.st      = BR_IDLE;
            n_d.dev     = 1'b1;
        end else if (fall_i) begin
            n_d.dev = 1'b1;
        end else if (rise_i) begin
            unique case (n_q.st)
                BR_WR: begin
                    n_d.sh  = {n_q.sh[DATA_W-2:0], bit_i};
                    n_d.cnt = n_q.cnt + CNT_W'(1);
                    n_d.dev = 1'b1;
                    if (n_q.cnt == LAST) n_d.st = BR_ACK;
                end
                BR_ACK: begin
                    if (!n_q.addr_ok) begin
                        req_start_o = 1'b1;
                        n_d.addr_ok = 1'b1;
                        n_d.rd_dir  = n_q.sh[0];
                        dir_v       = n_q.sh[0];
                    end else begin
                        req_write_o = 1'b1;
                    end
                    n_d.cnt = '0;
                    if (refuse_i) begin
                        req_end_o   = 1'b1;
                        n_d.addr_ok = 1'b0;
                        n_d.st      = BR_IDLE;
                        n_d.dev     = 1'b1;
                    end else begin
                        n_d.dev = 1'b0;
                        n_d.st  = dir_v ? BR_RD : BR_WR;
                    end
                end
                BR_RD: begin
                    if (n_q.cnt == '0) begin
                        req_read_o = 1'b1;
                        byte_v     = rdata_i;
                    end
                    n_d.dev = byte_v[DATA_W-1];
                    n_d.sh  = {byte_v[DATA_W-2:0], 1'b0};
                    n_d.cnt = n_q.cnt + CNT_W'(1);
                    if (n_q.cnt == LAST) n_d.st = BR_MACK;
                end
                BR_MACK: begin
                    n_d.dev = 1'b1;
                    n_d.cnt = '0;
                    if (bit_i) begin
                        req_nack_o = 1'b1;
                        n_d.st     = BR_HOLD;
                    end else begin
                        n_d.st = BR_RD;
                    end
                end
                default: begin
                    n_d.dev = 1'b1;
                end
            endcase
        end
        dev_d_o = n_d.dev;
        dev_q_o = n_q.dev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q <= '{st: BR_IDLE, cnt: '0, sh: '0, addr_ok: 1'b0,
                     rd_dir: 1'b0, dev: 1'b1};
        end else begin
            n_q <= n_d;
        end
    end

    AST_FALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i |=> n_q.dev); // R10
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (n_q.st == BR_IDLE) && !n_q.addr_ok); // R3
    AST_END_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        req_end_o |-> (n_q.addr_ok || req_start_o)); // R7
    AST_REFUSE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start_o || req_write_o) && refuse_i |=> n_q.dev && (n_q.st == BR_IDLE)); // R7
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_any |=> $stable(n_q)); // R4
    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_start_o, req_write_o, req_read_o, req_nack_o})); // R8
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (n_q.st == BR_WR) && !n_q.addr_ok && (n_q.cnt == '0)); // R2

endmodule

// File: rtl/i2cb_line_out.sv
module i2cb_line_out (
    input  logic clk,
    input  logic rst_n,
    input  logic dev_d_i,
    input  logic sda_i,
    output logic line_o
);

    typedef struct packed {
        logic lvl;
    } line_t;

    line_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if ((dev_d_i & sda_i) != l_q.lvl) l_d.lvl = dev_d_i & sda_i;
        line_o = l_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) l_q <= '{lvl: 1'b1};
        else        l_q <= l_d;
    end

    AST_LINE_LOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(l_q.lvl) |-> ($past(sda_i) == 1'b0) || ($past(dev_d_i) == 1'b0)); // R10

endmodule

// File: rtl/i2c_bitbang_bridge.sv
module i2c_bitbang_bridge #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              dev_sda_o,
    output logic              line_o,
    output logic              req_start_o,
    output logic [DATA_W-2:0] req_addr_o,
    output logic              req_rd_o,
    output logic              req_write_o,
    output logic [DATA_W-1:0] req_wdata_o,
    output logic              req_read_o,
    input  logic [DATA_W-1:0] rsp_rdata_i,
    input  logic              rsp_refuse_i,
    output logic              req_nack_o,
    output logic              req_end_o
);

    logic ev_start, ev_stop, ev_rise, ev_fall, ev_bit;
    logic dev_next;

    i2cb_edge_track u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .start_o (ev_start),
        .stop_o  (ev_stop),
        .rise_o  (ev_rise),
        .fall_o  (ev_fall),
        .bit_o   (ev_bit)
    );

    i2cb_core #(.DATA_W(DATA_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (ev_start),
        .stop_i      (ev_stop),
        .rise_i      (ev_rise),
        .fall_i      (ev_fall),
        .bit_i       (ev_bit),
        .rdata_i     (rsp_rdata_i),
        .refuse_i    (rsp_refuse_i),
        .dev_d_o     (dev_next),
        .dev_q_o     (dev_sda_o),
        .req_start_o (req_start_o),
        .req_addr_o  (req_addr_o),
        .req_rd_o    (req_rd_o),
        .req_write_o (req_write_o),
        .req_wdata_o (req_wdata_o),
        .req_read_o  (req_read_o),
        .req_nack_o  (req_nack_o),
        .req_end_o   (req_end_o)
    );

    i2cb_line_out u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .dev_d_i (dev_next),
        .sda_i   (sda_i),
        .line_o  (line_o)
    );

    AST_RESET_RELEASED: assert property (@(posedge clk)
        !rst_n |=> dev_sda_o && line_o); // R1

endmodule

// File: tb/tb_i2c_bitbang_bridge.sv
`timescale 1ns/1ps
module tb_i2c_bitbang_bridge;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic dev_sda, line;
    logic req_start, req_rd, req_write, req_read, req_nack, req_end;
    logic [6:0] req_addr;
    logic [7:0] req_wdata, rsp_rdata;
    logic rsp_refuse;
    int   rd_k;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    i2c_bitbang_bridge #(.DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .dev_sda_o(dev_sda), .line_o(line),
        .req_start_o(req_start), .req_addr_o(req_addr), .req_rd_o(req_rd),
        .req_write_o(req_write), .req_wdata_o(req_wdata), .req_read_o(req_read),
        .rsp_rdata_i(rsp_rdata), .rsp_refuse_i(rsp_refuse),
        .req_nack_o(req_nack), .req_end_o(req_end)
    );

    function automatic logic present(input logic [6:0] a);
        return a[6:3] == 4'b1010;
    endfunction

    function automatic logic [7:0] rdat(input int k);
        return 8'h5A ^ 8'(k * 37);
    endfunction

    // responder modelling present/absent targets
    always_comb begin
        rsp_refuse = (req_start && !present(req_addr)) || (req_write && req_wdata == 8'hFF);
        rsp_rdata  = rdat(rd_k);
    end
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_k <= 0;
        else if (req_read) rd_k <= rd_k + 1;
    end

    logic f_start, f_write, f_nack, f_end, l_dir;
    int   n_read;
    logic [6:0] l_addr;
    logic [7:0] l_wdata;
    int   exp_k = 0;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clr_ev;
        f_start = 0; f_write = 0; f_nack = 0; f_end = 0; n_read = 0;
    endtask

    task automatic step(input logic c, input logic d);
        @(negedge clk);
        scl = c; sda = d;
        #2;
        if (req_start) begin f_start = 1; l_addr = req_addr; l_dir = req_rd; end
        if (req_write) begin f_write = 1; l_wdata = req_wdata; end
        if (req_read)  n_read++;
        if (req_nack)  f_nack = 1;
        if (req_end)   f_end = 1;
        @(posedge clk); #2;
    endtask

    task automatic m_start;
        step(scl, 1);
        if (!scl) step(1, 1);
        step(1, 0);
        step(0, 0);
    endtask

    task automatic m_stop;
        step(0, 0);
        step(1, 0);
        step(1, 1);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            step(0, b[i]);
            step(1, b[i]);
        end
        step(0, 1);
        step(1, 1);
        ack = !line;
        step(0, 1);
    endtask

    task automatic read_byte(input logic mnack, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            step(0, 1);
            step(1, 1);
            got[i] = line;
        end
        step(0, mnack);
        step(1, mnack);
        step(0, mnack);
    endtask

    // address phase; returns acceptance
    task automatic do_addr(input logic [6:0] a, input logic dir, output logic ok);
        logic ack;
        clr_ev;
        send_byte({a, dir}, ack);
        chk(f_start && l_addr == a && l_dir == dir, "R5 start request", {l_addr, l_dir}, {a, dir});
        chk(ack == present(a), "R7 address ack", ack, present(a));
        if (!present(a)) chk(f_end, "R7 end on refused address", f_end, 1);
        ok = ack;
    endtask

    task automatic do_write(input logic [7:0] d, output logic ok);
        logic ack;
        clr_ev;
        send_byte(d, ack);
        chk(f_write && l_wdata == d && !f_start, "R6 write request", l_wdata, d);
        chk(ack == (d != 8'hFF), "R6 data ack", ack, d != 8'hFF);
        if (d == 8'hFF) chk(f_end, "R7 end on refused data", f_end, 1);
        ok = ack;
    endtask

    task automatic do_read(input logic last);
        logic [7:0] got;
        clr_ev;
        read_byte(last, got);
        chk(got == rdat(exp_k), "R8 read byte", got, rdat(exp_k));
        chk(n_read == 1, "R8 one read request per byte", n_read, 1);
        chk(f_nack == last, "R9 nack request", f_nack, last);
        exp_k++;
    endtask

    task automatic do_stop(input logic exp_end);
        clr_ev;
        m_stop;
        chk(f_end == exp_end, "R3 end on stop", f_end, exp_end);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic ok, ack;
        logic [7:0] b;
        int r;
        r = $urandom(32'h2BAD);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        clr_ev;
        step(1, 1);
        step(1, 1);
        // R1 reset state
        chk(dev_sda && line, "R1 released after reset", {dev_sda, line}, 2'b11);
        chk(!f_start && !f_write && n_read == 0 && !f_nack && !f_end, "R1 no requests", 0, 0);

        // R10 line is device AND master data
        step(0, 1);
        step(0, 0);
        chk(line == 1'b0 && dev_sda, "R10 line follows master low", line, 0);
        step(0, 1);
        step(1, 1);

        // R3 STOP without accepted address: no end
        m_start;
        do_stop(1'b0);

        // R4 toggles while clock low do not enter the shift register
        clr_ev;
        m_start;
        b = {7'h52, 1'b0};
        for (int i = 7; i >= 0; i--) begin
            step(0, ~b[i]);
            step(0, b[i]);
            step(0, ~b[i]);
            step(0, b[i]);
            step(0, b[i]);
            step(1, b[i]);
            step(1, b[i]);
        end
        step(0, 1);
        step(1, 1);
        ack = !line;
        chk(f_start && l_addr == 7'h52 && !l_dir, "R4 address unaffected by low-clock toggles", l_addr, 7'h52);
        chk(ack && !f_end, "R6 address acknowledged", ack, 1);
        chk(dev_sda == 1'b0, "R6 ack driven low", dev_sda, 0);
        step(0, 1);
        chk(dev_sda && line, "R10 fall releases output", {dev_sda, line}, 2'b11);

        // R2 repeated start mid-write: no end, next byte is an address
        do_write(8'h3C, ok);
        clr_ev;
        m_start;
        chk(!f_end, "R2 repeated start raises no end", f_end, 0);
        do_addr(7'h55, 1'b1, ok);
        do_read(1'b0);
        do_read(1'b1);
        // R9 held after master NACK
        clr_ev;
        for (int i = 0; i < 9; i++) begin
            step(0, i[0]);
            step(1, i[0]);
            chk(dev_sda, "R9 output released while held", dev_sda, 1);
        end
        chk(!f_start && !f_write && n_read == 0 && !f_nack && !f_end, "R9 no requests while held", 0, 0);
        do_stop(1'b1);

        // R7 refused address: later clocks idle, stop raises nothing
        m_start;
        do_addr(7'h11, 1'b0, ok);
        clr_ev;
        send_byte(8'h00, ack);
        chk(!ack && !f_write && !f_start, "R7 idle after refusal", ack, 0);
        do_stop(1'b0);

        // R7 refused data byte
        m_start;
        do_addr(7'h50, 1'b0, ok);
        do_write(8'hFF, ok);
        do_stop(1'b0);

        // constrained random transactions
        for (int t = 0; t < 24; t++) begin
            logic [6:0] a;
            logic dir;
            int nb;
            a   = ($urandom % 2) ? {4'b1010, 3'($urandom)} : 7'($urandom);
            dir = 1'($urandom);
            nb  = 1 + ($urandom % 3);
            m_start;
            do_addr(a, dir, ok);
            if (ok) begin
                for (int k = 0; k < nb && ok; k++) begin
                    if (dir) begin
                        do_read(k == nb - 1);
                    end else begin
                        b = ($urandom % 5 == 0) ? 8'hFF : 8'($urandom % 255);
                        do_write(b, ok);
                    end
                end
            end
            do_stop(ok);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule